// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds the running time and date of a real-time clock: seconds, minutes, hours (24-hour), day of the week, day of the month, month and a two-digit year. A divider elsewhere in the chip sends it a one-cycle strobe once per second. Each strobe that is not blocked moves the time on by one second. Carries ripple through every field and take account of the month length and of leap years.

A mode input selects how the fields are stored. Low selects packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. High selects plain binary. A hold input lets software change fields without the clock running underneath it. A field-load port writes any single field verbatim. The mode input does not re-encode stored values. Software reloads the fields after it changes the mode.

Top module: `rtc_calendar_core`

## Requirements
- R1: While reset is asserted, seconds, minutes, hours and year read 0, and day of week, day of month and month read 1.
- R2: With the mode input at 0, fields are packed BCD; with it at 1 they are binary. A strobe steps seconds by one in that encoding: BCD 0x09 becomes 0x10, and binary 9 becomes 0x0A.
- R3: Seconds and minutes wrap from 59 to 0 and carry one into the next field.
- R4: Hours wrap from 23 to 0, and that wrap advances the day of month and the day of week.
- R5: Day of week counts 1 to 7, with 1 meaning Sunday, and wraps from 7 to 1.
- R6: Day of month wraps to 1 after 30 in months 4, 6, 9 and 11, after 31 in the other long months, and after 28 or 29 in month 2. The wrap advances the month.
- R7: Year values 00 to 49 stand for 2000 to 2049, and 50 to 99 stand for 1950 to 1999. February has 29 days in a Gregorian leap year of that range (for example 00, 24, 96) and 28 days otherwise (for example 23).
- R8: Month wraps from 12 to 1 and advances the year. Year wraps from 99 to 00.
- R9: While the hold input is 1, a strobe changes no field.
- R10: In a cycle with neither a strobe nor a load, no field changes.
- R11: A load writes the load data verbatim into the selected field on the next clock edge. The select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year and 7 nothing. A load cycle ignores a strobe in the same cycle, so no other field advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance strobe |
| hold_i | input | 1 | Freeze the counter while high |
| bin_mode_i | input | 1 | 0 selects packed BCD, 1 selects binary |
| ld_en_i | input | 1 | Field load enable |
| ld_sel_i | input | 3 | Field select for a load |
| ld_data_i | input | 8 | Value to load |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The bench builds the block with its defaults: 8-bit fields, a century pivot at 50 and the full Gregorian leap rule. With that rule, the pivot decides whether year 00 means the leap year 2000. The bench loads values one or two seconds before a boundary, so New Year, leap and non-leap February and 30-day month wraps each take only a few strobes. Both storage modes are tried from reset.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int FIELD_W  = 8;
   localparam int N_FIELDS = 7;

   typedef enum logic [2:0] {
      F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_WDAY = 3'd3,
      F_MDAY = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6, F_NONE = 3'd7
   } field_sel_e;

   function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bin);
      logic [7:0] t;
      t = {4'd0, v[7:4]};
      return bin ? v : (t << 3) + (t << 1) + {4'd0, v[3:0]};
   endfunction

   function automatic logic [7:0] from_bin(input logic [7:0] v, input logic bin);
      logic [7:0] tens, units;
      tens  = v / 8'd10;
      units = v % 8'd10;
      return bin ? v : {tens[3:0], units[3:0]};
   endfunction

   function automatic logic [7:0] field_lo(input int idx);
      return (idx == 3 || idx == 4 || idx == 5) ? 8'd1 : 8'd0;
   endfunction

   function automatic logic [7:0] field_hi(input int idx);
      case (idx)
         0, 1:    return 8'd59;
         2:       return 8'd23;
         3:       return 8'd7;
         4:       return 8'd31;
         5:       return 8'd12;
         default: return 8'd99;
      endcase
   endfunction
endpackage

// File: rtl/rtc_field_unit.sv
module rtc_field_unit #(
   parameter int FW = 8,
   parameter logic [FW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic          ld_i,
   input  logic [FW-1:0] ld_val_i,
   input  logic          bin_mode_i,
   input  logic [FW-1:0] lo_i,
   input  logic [FW-1:0] hi_i,
   output logic [FW-1:0] q_o,
   output logic          wrap_o
);
   logic [FW-1:0] cur_bin, nxt_bin;

   assign cur_bin = rtc_cal_pkg::to_bin(q_o, bin_mode_i);
   assign wrap_o  = adv_i && (cur_bin >= hi_i);
   assign nxt_bin = wrap_o ? lo_i : cur_bin + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RST_VAL;
      else if (ld_i)   q_o <= ld_val_i;
      else if (adv_i)  q_o <= rtc_cal_pkg::from_bin(nxt_bin, bin_mode_i);
   end
endmodule

// File: rtl/rtc_day_limit.sv
module rtc_day_limit #(
   parameter int FW         = 8,
   parameter int PIVOT      = 50,
   parameter bit FULL_RULE  = 1'b1
) (
   input  logic [FW-1:0] mon_bin_i,
   input  logic [FW-1:0] yr_bin_i,
   output logic [FW-1:0] len_o
);
   localparam logic [FW-1:0] PIV = FW'(PIVOT);
   logic leap;

   generate
      if (FULL_RULE) begin : g_greg
         logic [11:0] full_yr;
         assign full_yr = (yr_bin_i < PIV) ? 12'd2000 + 12'(yr_bin_i)
                                           : 12'd1900 + 12'(yr_bin_i);
         assign leap = (full_yr % 12'd4 == 12'd0) &&
                       ((full_yr % 12'd100 != 12'd0) || (full_yr % 12'd400 == 12'd0));
      end else begin : g_mod4
         assign leap = (yr_bin_i[1:0] == 2'b00);
      end
   endgenerate

   always_comb begin
      case (mon_bin_i)
         FW'(2):                   len_o = leap ? FW'(29) : FW'(28);
         FW'(4), FW'(6), FW'(9), FW'(11): len_o = FW'(30);
         default:                  len_o = FW'(31);
      endcase
   end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
   parameter int FW        = 8,
   parameter int PIVOT     = 50,
   parameter bit FULL_RULE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          hold_i,
   input  logic          bin_mode_i,
   input  logic          ld_en_i,
   input  logic [2:0]    ld_sel_i,
   input  logic [FW-1:0] ld_data_i,
   output logic [FW-1:0] sec_o,
   output logic [FW-1:0] min_o,
   output logic [FW-1:0] hour_o,
   output logic [FW-1:0] wday_o,
   output logic [FW-1:0] mday_o,
   output logic [FW-1:0] mon_o,
   output logic [FW-1:0] year_o
);
   import rtc_cal_pkg::*;
   localparam int NF = N_FIELDS;

   generate
      if (FW != FIELD_W) begin : g_bad_fw
         $error("rtc_calendar_core: FW must equal 8 for two-digit BCD fields");
      end
      if (PIVOT < 0 || PIVOT > 99) begin : g_bad_piv
         $error("rtc_calendar_core: PIVOT must lie in 0..99");
      end
   endgenerate

   logic [FW-1:0] fq   [NF];
   logic [NF-1:0] adv, wrap, ld;
   logic [FW-1:0] day_len;
   logic          step;

   assign step = tick_i && !hold_i && !ld_en_i;

   always_comb begin
      adv[F_SEC]  = step;
      adv[F_MIN]  = wrap[F_SEC];
      adv[F_HOUR] = wrap[F_MIN];
      adv[F_WDAY] = wrap[F_HOUR];
      adv[F_MDAY] = wrap[F_HOUR];
      adv[F_MON]  = wrap[F_MDAY];
      adv[F_YEAR] = wrap[F_MON];
   end

   rtc_day_limit #(.FW(FW), .PIVOT(PIVOT), .FULL_RULE(FULL_RULE)) u_limit (
      .mon_bin_i (to_bin(fq[F_MON], bin_mode_i)),
      .yr_bin_i  (to_bin(fq[F_YEAR], bin_mode_i)),
      .len_o     (day_len)
   );

   for (genvar i = 0; i < NF; i++) begin : g_field
      assign ld[i] = ld_en_i && (ld_sel_i == 3'(i));
      rtc_field_unit #(.FW(FW), .RST_VAL(field_lo(i))) u_fld (
         .clk        (clk),
         .rst_n      (rst_n),
         .adv_i      (adv[i]),
         .ld_i       (ld[i]),
         .ld_val_i   (ld_data_i),
         .bin_mode_i (bin_mode_i),
         .lo_i       (field_lo(i)),
         .hi_i       ((i == 4) ? day_len : field_hi(i)),
         .q_o        (fq[i]),
         .wrap_o     (wrap[i])
      );
   end

   assign sec_o  = fq[F_SEC];
   assign min_o  = fq[F_MIN];
   assign hour_o = fq[F_HOUR];
   assign wday_o = fq[F_WDAY];
   assign mday_o = fq[F_MDAY];
   assign mon_o  = fq[F_MON];
   assign year_o = fq[F_YEAR];
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
   parameter int FW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_i,
   input logic          hold_i,
   input logic          bin_mode_i,
   input logic          ld_en_i,
   input logic [2:0]    ld_sel_i,
   input logic [FW-1:0] ld_data_i,
   input logic [FW-1:0] sec_o,
   input logic [FW-1:0] min_o,
   input logic [FW-1:0] hour_o,
   input logic [FW-1:0] wday_o,
   input logic [FW-1:0] mday_o,
   input logic [FW-1:0] mon_o,
   input logic [FW-1:0] year_o
);
   import rtc_cal_pkg::*;
   logic go;
   logic [FW-1:0] sb, mb, hb;
   assign go = tick_i && !hold_i && !ld_en_i;
   assign sb = to_bin(sec_o, bin_mode_i);
   assign mb = to_bin(min_o, bin_mode_i);
   assign hb = to_bin(hour_o, bin_mode_i);

   assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i && !ld_en_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o));

   assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !ld_en_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o));

   assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      go && sb < 8'd59 |=> (bin_mode_i != $past(bin_mode_i)) ||
      (to_bin(sec_o, bin_mode_i) == $past(sb) + 8'd1 && $stable(min_o)));

   assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      go && sb == 8'd59 |=> sec_o == 8'd0);

   assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      go && sb == 8'd59 && mb == 8'd59 && hb == 8'd23 |=> hour_o == 8'd0 && !$stable(wday_o));

   assert_load_sec_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i && ld_sel_i == 3'd0 |=> sec_o == $past(ld_data_i));

   assert_load_year_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i && ld_sel_i == 3'd6 |=> year_o == $past(ld_data_i));

   assert_load_blocks_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i && ld_sel_i != 3'd0 |=> $stable(sec_o));
endmodule

bind rtc_calendar_core rtc_calendar_chk #(.FW(FW)) chk_i (.*);

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, hold = 1'b0, mode = 1'b0, ld_en = 1'b0;
   logic [2:0] sel = 3'd7;
   logic [7:0] data = 8'd0;
   logic [7:0] dq [7];
   int checks = 0, fails = 0, cycles = 0;
   int m [7];
   string phase = "R1";

   always #10 clk = ~clk;

   rtc_calendar_core dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(hold), .bin_mode_i(mode),
      .ld_en_i(ld_en), .ld_sel_i(sel), .ld_data_i(data),
      .sec_o(dq[0]), .min_o(dq[1]), .hour_o(dq[2]), .wday_o(dq[3]),
      .mday_o(dq[4]), .mon_o(dq[5]), .year_o(dq[6])
   );

   function automatic int enc(int v, bit b);
      return b ? v : ((v / 10) << 4) | (v % 10);
   endfunction
   function automatic int dec(int v, bit b);
      return b ? v : (v >> 4) * 10 + (v & 15);
   endfunction
   function automatic int mlen(int mo, int yr);
      int fy;
      bit lp;
      fy = (yr < 50) ? 2000 + yr : 1900 + yr;
      lp = (fy % 4 == 0) && ((fy % 100 != 0) || (fy % 400 == 0));
      if (mo == 2) return lp ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 1; m[4] = 1; m[5] = 1; m[6] = 0;
      end else if (ld_en) begin
         if (sel < 7) m[sel] = dec(data, mode);
      end else if (tick && !hold) begin
         if (m[0] < 59) m[0]++;
         else begin
            m[0] = 0;
            if (m[1] < 59) m[1]++;
            else begin
               m[1] = 0;
               if (m[2] < 23) m[2]++;
               else begin
                  m[2] = 0;
                  m[3] = (m[3] >= 7) ? 1 : m[3] + 1;
                  if (m[4] < mlen(m[5], m[6])) m[4]++;
                  else begin
                     m[4] = 1;
                     if (m[5] < 12) m[5]++;
                     else begin
                        m[5] = 1;
                        m[6] = (m[6] >= 99) ? 0 : m[6] + 1;
                     end
                  end
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 7; i++) begin
            checks++;
            if (int'(dq[i]) != enc(m[i], mode)) begin
               fails++;
               $display("FAIL %s model field %0d actual=%h expected=%h", phase, i, dq[i], enc(m[i], mode));
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic do_reset(bit md);
      @(negedge clk);
      rst_n = 1'b0; mode = md;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ld(int s, int v);
      ld_en = 1'b1; sel = 3'(s); data = 8'(v);
      @(negedge clk);
      ld_en = 1'b0; sel = 3'd7;
   endtask

   task automatic tk(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic set_all(int s, int mi, int h, int wd, int md, int mo, int y);
      ld(0, s); ld(1, mi); ld(2, h); ld(3, wd); ld(4, md); ld(5, mo); ld(6, y);
   endtask

   initial begin
      // R1 reset values
      @(negedge clk);
      chk("R1 sec", dq[0], 0); chk("R1 wday", dq[3], 1);
      chk("R1 mday", dq[4], 1); chk("R1 mon", dq[5], 1); chk("R1 year", dq[6], 0);
      do_reset(1'b0);

      // R2 BCD step
      phase = "R2";
      ld(0, 'h09); tk(1);
      chk("R2 bcd sec 09->10", dq[0], 'h10);

      // R3 R4 R5 R6 R8 New Year
      phase = "R8";
      set_all('h58, 'h59, 'h23, 7, 'h31, 'h12, 'h99);
      tk(1);
      chk("R3 sec to 59", dq[0], 'h59);
      tk(1);
      chk("R3 sec wrap", dq[0], 'h00); chk("R3 min wrap", dq[1], 'h00);
      chk("R4 hour wrap", dq[2], 'h00); chk("R5 wday 7->1", dq[3], 1);
      chk("R6 mday 31->1", dq[4], 'h01); chk("R8 mon 12->1", dq[5], 'h01);
      chk("R8 year 99->00", dq[6], 'h00);

      // R7 leap years
      phase = "R7";
      set_all('h59, 'h59, 'h23, 2, 'h28, 'h02, 'h24);
      tk(1);
      chk("R7 2024 feb 29", dq[4], 'h29);
      set_all('h59, 'h59, 'h23, 2, 'h29, 'h02, 'h24);
      tk(1);
      chk("R7 2024 mar 1 day", dq[4], 'h01); chk("R7 2024 mar 1 mon", dq[5], 'h03);
      set_all('h59, 'h59, 'h23, 2, 'h28, 'h02, 'h23);
      tk(1);
      chk("R7 2023 feb 28->mar", dq[5], 'h03);
      set_all('h59, 'h59, 'h23, 2, 'h28, 'h02, 'h96);
      tk(1);
      chk("R7 1996 feb 29", dq[4], 'h29);
      set_all('h59, 'h59, 'h23, 2, 'h28, 'h02, 'h00);
      tk(1);
      chk("R7 2000 feb 29", dq[4], 'h29);

      // R6 30-day month
      phase = "R6";
      set_all('h59, 'h59, 'h23, 3, 'h30, 'h04, 'h10);
      tk(1);
      chk("R6 apr 30->may 1 day", dq[4], 'h01); chk("R6 may", dq[5], 'h05);
      set_all('h59, 'h59, 'h23, 3, 'h30, 'h05, 'h10);
      tk(1);
      chk("R6 may 31", dq[4], 'h31);

      // R9 hold
      phase = "R9";
      hold = 1'b1; tk(5); hold = 1'b0;
      chk("R9 hold sec", dq[0], 'h00); chk("R9 hold mday", dq[4], 'h31);

      // R10 idle
      phase = "R10";
      repeat (4) @(negedge clk);
      chk("R10 idle sec", dq[0], 'h00);

      // R11 load beats tick, select 7 writes nothing
      phase = "R11";
      ld(0, 'h30);
      tick = 1'b1; ld(2, 'h11); tick = 1'b0;
      chk("R11 hour loaded", dq[2], 'h11); chk("R11 sec not advanced", dq[0], 'h30);
      ld(7, 'h42);
      chk("R11 sel7 sec", dq[0], 'h30); chk("R11 sel7 year", dq[6], 'h10);

      // R2 binary mode
      do_reset(1'b1);
      phase = "R2";
      ld(0, 9); tk(1);
      chk("R2 bin sec 9->10", dq[0], 'h0A);
      set_all(59, 59, 23, 7, 31, 12, 49);
      tk(1);
      chk("R8 bin year 49->50", dq[6], 50); chk("R5 bin wday", dq[3], 1);

      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule